// File: doc/BRIEF.md
# 16-bit Capture/Compare Timer with Byte-Wide Register Access

This block is a timer built on a free-running 16-bit up counter that advances on every cycle in which the `tick` enable is high. Two input-capture channels store the counter value when a chosen edge appears on their pins. This lets software measure the length of pulses on two separate inputs. Two output-compare channels watch the counter. When it reaches a programmed value, each channel either flips its output pin or drives the pin to a programmed level.

Software reaches every 16-bit quantity through an 8-bit register bus, as a pair of byte registers. A high-byte access locks the function until the matching low-byte access releases it, so the two bytes always belong together:
- For the counter, reading the high byte freezes a copy of the low byte.
- For a capture channel, reading the high byte stops new captures.
- For a compare channel, writing the high byte stops matches.

Every capture, every compare match and the counter wrap each raise a sticky flag. Each flag has its own interrupt enable, and the flags are combined into one interrupt request.

Top module: `cct_timer`

## Requirements
- R1: After reset the counter reads 0, the flag register (offset 5) and enable register (offset 4) read 0, both compare pins and `irq` are low, and both compare channels are disarmed.
- R2: The counter increments by one on each cycle with `tick` high and otherwise holds. Reading offset 0 returns the counter's upper byte and stores its lower byte in a buffer. Reading offset 1 returns that buffer, so the pair gives the counter value at the high-byte read.
- R3: Bit k of the edge register (offset 2) selects the active edge of capture pin k: 1 for rising, 0 for falling. On an active edge, capture k (high byte at offset 6+2k, low byte at 7+2k) stores the counter value of the cycle in which the new pin level is first presented, and flag bit k is set.
- R4: An edge of the inactive polarity on a capture pin leaves that capture value and flag bit k unchanged.
- R5: Reading a capture high byte blocks captures on that channel until its low byte is read. This includes an active edge presented in the same cycle as the high-byte read. A blocked edge neither changes the value nor sets the flag. After the low byte is read, edges are captured again.
- R6: Compare j has its high byte at offset 10+2j and its low byte at 11+2j. In a cycle where compare j is armed, `tick` is high and the counter equals the compare value, the channel matches. Flag bit 2+j is set. If bit j of the action register (offset 3) is 0, pin j toggles on the following cycle.
- R7: With action bit j set to 1, a match loads compare pin j with level bit 2+j of the action register.
- R8: Writing a compare high byte disarms that channel, so a counter equal to the stored value produces no match and no pin change. Writing its low byte re-arms it.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it. Bit 4 of the flag register is the counter wrap flag. The enable register uses the same bit layout as the flag register. `irq` is high exactly when some flag bit and its enable bit are both 1.
- R10: When a flag is cleared by software in the same cycle as a new event for it occurs, the flag ends up set.
- R11: A cycle with `tick` high while the counter is 0xFFFF sets flag bit 4, and the counter rolls over to 0.
- R12: Writes to the counter offsets (0, 1) and the capture offsets have no effect on the counter or the captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter advance enable |
| bus_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| cap_pin | input | 2 | Capture inputs, one per channel |
| cmp_pin | output | 2 | Compare outputs, one per channel |
| irq | output | 1 | Interrupt request |

## Verification
Two cases need care because a bus access and a timer event can land in the same cycle. In the first, the bench presents an active capture edge in the same cycle as the high-byte read of that capture channel. It then confirms through the flag register and the low-byte read that the edge was dropped and the old value kept. In the second, a write-one-to-clear of a capture flag coincides with a fresh active edge on that pin. The flag must read back as set afterwards. Random pauses in `tick` between counter high and low reads exercise the read buffer against a bench-side counter model.

// File: rtl/cct_pkg.sv
package cct_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned CNT_W  = 2 * BYTE_W;

   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [CNT_W-1:0]  count_t;

   // register offsets whose placement other logic decodes
   localparam int unsigned OFS_CNT_HI   = 0;
   localparam int unsigned OFS_CNT_LO   = 1;
   localparam int unsigned OFS_EDGE     = 2;
   localparam int unsigned OFS_ACT      = 3;
   localparam int unsigned OFS_IEN      = 4;
   localparam int unsigned OFS_FLAG     = 5;
   localparam int unsigned OFS_CAP_BASE = 6;
endpackage

// File: rtl/cct_counter.sv
module cct_counter
   import cct_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   tick,
   input  logic   hi_rd,
   output count_t cnt,
   output byte_t  lo_buf,
   output logic   wrap_evt
);
   count_t cnt_q;
   byte_t  buf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         buf_q <= '0;
      end else begin
         if (tick)  cnt_q <= cnt_q + 1'b1;
         if (hi_rd) buf_q <= cnt_q[BYTE_W-1:0];
      end
   end

   assign cnt      = cnt_q;
   assign lo_buf   = buf_q;
   assign wrap_evt = tick && (cnt_q == '1);

   // R2: step by one on tick, hold otherwise
   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> cnt_q == count_t'($past(cnt_q) + 1'b1));
   a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q));
   // R2: buffer keeps the low byte seen at the high-byte read
   a_r2_lo_buffer: assert property (@(posedge clk) disable iff (!rst_n)
      hi_rd |=> buf_q == $past(cnt_q[BYTE_W-1:0]));
endmodule

// File: rtl/cct_capture.sv
module cct_capture
   import cct_pkg::*;
#(
   parameter int unsigned SYNC_EN = 0
)(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pin,
   input  logic   rise_sel,
   input  count_t cnt,
   input  logic   hi_rd,
   input  logic   lo_rd,
   output count_t val,
   output logic   evt
);
   logic   sampled;
   logic   prev_q;
   logic   blk_q;
   logic   edge_seen;
   count_t val_q;

   if (SYNC_EN != 0) begin : g_sync
      logic s1_q, s2_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
         end else begin
            s1_q <= pin;
            s2_q <= s1_q;
         end
      end
      assign sampled = s2_q;
   end else begin : g_direct
      assign sampled = pin;
   end

   assign edge_seen = rise_sel ? (sampled & ~prev_q) : (~sampled & prev_q);
   // a high-byte read in this very cycle already locks the channel
   assign evt = edge_seen && !blk_q && !hi_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         blk_q  <= 1'b0;
         val_q  <= '0;
      end else begin
         prev_q <= sampled;
         if (evt) val_q <= cnt;
         if (hi_rd)      blk_q <= 1'b1;
         else if (lo_rd) blk_q <= 1'b0;
      end
   end

   assign val = val_q;

   // R5: a locked channel keeps its value
   a_r5_blocked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      blk_q |=> $stable(val_q));
   // R3: a capture stores the counter of the event cycle
   a_r3_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> val_q == $past(cnt));
endmodule

// File: rtl/cct_compare.sv
module cct_compare
   import cct_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   tick,
   input  count_t cnt,
   input  logic   wr_hi,
   input  logic   wr_lo,
   input  byte_t  wdata,
   input  logic   load_mode,
   input  logic   level,
   output count_t val,
   output logic   pin,
   output logic   evt
);
   count_t val_q;
   logic   armed_q;
   logic   pin_q;

   assign evt = tick && armed_q && !wr_hi && (cnt == val_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q   <= '0;
         armed_q <= 1'b0;
         pin_q   <= 1'b0;
      end else begin
         if (wr_hi) begin
            val_q[CNT_W-1:BYTE_W] <= wdata;
            armed_q               <= 1'b0;
         end else if (wr_lo) begin
            val_q[BYTE_W-1:0] <= wdata;
            armed_q           <= 1'b1;
         end
         if (evt) pin_q <= load_mode ? level : ~pin_q;
      end
   end

   assign val = val_q;
   assign pin = pin_q;

   // R8: a disarmed channel never moves its pin
   a_r8_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |=> $stable(pin_q));
   // R6: toggle action
   a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !load_mode) |=> pin_q != $past(pin_q));
   // R7: level action
   a_r7_load_level: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && load_mode) |=> pin_q == $past(level));
endmodule

// File: rtl/cct_timer.sv
module cct_timer
   import cct_pkg::*;
#(
   parameter int unsigned N_CAP    = 2,
   parameter int unsigned N_CMP    = 2,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned SYNC_CAP = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic [N_CAP-1:0]  cap_pin,
   output logic [N_CMP-1:0]  cmp_pin,
   output logic              irq
);
   localparam int unsigned CAP_BASE = OFS_CAP_BASE;
   localparam int unsigned CMP_BASE = CAP_BASE + 2 * N_CAP;
   localparam int unsigned REG_END  = CMP_BASE + 2 * N_CMP;
   localparam int unsigned NFLAG    = N_CAP + N_CMP + 1;
   localparam int unsigned WRAP_BIT = N_CAP + N_CMP;

   if (N_CAP < 1 || N_CMP < 1) begin : g_chk_count
      $error("cct_timer: at least one channel of each kind is required");
   end
   if (NFLAG > BYTE_W || 2 * N_CMP > BYTE_W) begin : g_chk_fit
      $error("cct_timer: channel count does not fit the byte-wide registers");
   end
   if ((1 << ADDR_W) < REG_END) begin : g_chk_addr
      $error("cct_timer: ADDR_W too narrow for the register map");
   end

   count_t cnt;
   byte_t  cnt_lo_buf;
   logic   wrap_evt;
   logic   cnt_hi_rd;

   logic wr_edge, wr_act, wr_ien, wr_flag;

   logic [N_CAP-1:0] edge_q;
   logic [N_CMP-1:0] act_q;
   logic [N_CMP-1:0] lvl_q;
   logic [NFLAG-1:0] ien_q;
   logic [NFLAG-1:0] flag_q;
   logic [NFLAG-1:0] flag_set;
   logic [NFLAG-1:0] flag_clr;

   count_t           cap_val [N_CAP];
   logic [N_CAP-1:0] cap_evt;
   count_t           cmp_val [N_CMP];
   logic [N_CMP-1:0] cmp_evt;

   assign cnt_hi_rd = bus_rd && (bus_addr == ADDR_W'(OFS_CNT_HI));
   assign wr_edge   = bus_wr && (bus_addr == ADDR_W'(OFS_EDGE));
   assign wr_act    = bus_wr && (bus_addr == ADDR_W'(OFS_ACT));
   assign wr_ien    = bus_wr && (bus_addr == ADDR_W'(OFS_IEN));
   assign wr_flag   = bus_wr && (bus_addr == ADDR_W'(OFS_FLAG));

   cct_counter u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .hi_rd    (cnt_hi_rd),
      .cnt      (cnt),
      .lo_buf   (cnt_lo_buf),
      .wrap_evt (wrap_evt)
   );

   for (genvar k = 0; k < N_CAP; k++) begin : g_cap
      logic hi_rd, lo_rd;
      assign hi_rd = bus_rd && (bus_addr == ADDR_W'(CAP_BASE + 2 * k));
      assign lo_rd = bus_rd && (bus_addr == ADDR_W'(CAP_BASE + 2 * k + 1));
      cct_capture #(.SYNC_EN(SYNC_CAP)) u_cap (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin      (cap_pin[k]),
         .rise_sel (edge_q[k]),
         .cnt      (cnt),
         .hi_rd    (hi_rd),
         .lo_rd    (lo_rd),
         .val      (cap_val[k]),
         .evt      (cap_evt[k])
      );
   end

   for (genvar j = 0; j < N_CMP; j++) begin : g_cmp
      logic wr_hi, wr_lo;
      assign wr_hi = bus_wr && (bus_addr == ADDR_W'(CMP_BASE + 2 * j));
      assign wr_lo = bus_wr && (bus_addr == ADDR_W'(CMP_BASE + 2 * j + 1));
      cct_compare u_cmp (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (tick),
         .cnt       (cnt),
         .wr_hi     (wr_hi),
         .wr_lo     (wr_lo),
         .wdata     (bus_wdata),
         .load_mode (act_q[j]),
         .level     (lvl_q[j]),
         .val       (cmp_val[j]),
         .pin       (cmp_pin[j]),
         .evt       (cmp_evt[j])
      );
   end

   assign flag_set = {wrap_evt, cmp_evt, cap_evt};
   assign flag_clr = wr_flag ? bus_wdata[NFLAG-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_q <= '0;
         act_q  <= '0;
         lvl_q  <= '0;
         ien_q  <= '0;
         flag_q <= '0;
      end else begin
         if (wr_edge) edge_q <= bus_wdata[N_CAP-1:0];
         if (wr_act) begin
            act_q <= bus_wdata[N_CMP-1:0];
            lvl_q <= bus_wdata[2*N_CMP-1:N_CMP];
         end
         if (wr_ien) ien_q <= bus_wdata[NFLAG-1:0];
         // a new event outranks a clear in the same cycle
         flag_q <= (flag_q & ~flag_clr) | flag_set;
      end
   end

   assign irq = |(flag_q & ien_q);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_CNT_HI)) bus_rdata = cnt[CNT_W-1:BYTE_W];
      if (bus_addr == ADDR_W'(OFS_CNT_LO)) bus_rdata = cnt_lo_buf;
      if (bus_addr == ADDR_W'(OFS_EDGE))   bus_rdata = byte_t'(edge_q);
      if (bus_addr == ADDR_W'(OFS_ACT))    bus_rdata = byte_t'({lvl_q, act_q});
      if (bus_addr == ADDR_W'(OFS_IEN))    bus_rdata = byte_t'(ien_q);
      if (bus_addr == ADDR_W'(OFS_FLAG))   bus_rdata = byte_t'(flag_q);
      for (int k = 0; k < N_CAP; k++) begin
         if (bus_addr == ADDR_W'(CAP_BASE + 2 * k))     bus_rdata = cap_val[k][CNT_W-1:BYTE_W];
         if (bus_addr == ADDR_W'(CAP_BASE + 2 * k + 1)) bus_rdata = cap_val[k][BYTE_W-1:0];
      end
      for (int j = 0; j < N_CMP; j++) begin
         if (bus_addr == ADDR_W'(CMP_BASE + 2 * j))     bus_rdata = cmp_val[j][CNT_W-1:BYTE_W];
         if (bus_addr == ADDR_W'(CMP_BASE + 2 * j + 1)) bus_rdata = cmp_val[j][BYTE_W-1:0];
      end
   end

   for (genvar b = 0; b < NFLAG; b++) begin : g_flag_chk
      // R10: an event always leaves its flag set
      a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         flag_set[b] |=> flag_q[b]);
      // R9: write-one clears when no event competes
      a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_flag && bus_wdata[b] && !flag_set[b]) |=> !flag_q[b]);
   end
endmodule

// File: tb/cct_timer_tb.sv
`timescale 1ns/1ps
module cct_timer_tb;
   localparam logic [3:0] A_CNT_HI = 4'd0, A_CNT_LO = 4'd1, A_EDGE = 4'd2, A_ACT = 4'd3,
                          A_IEN = 4'd4, A_FLAG = 4'd5, A_CAP0 = 4'd6, A_CAP1 = 4'd8,
                          A_CMP0 = 4'd10, A_CMP1 = 4'd12;

   logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [1:0] cap_pin = '0;
   logic [1:0] cmp_pin;
   logic       irq;

   int n_cmp = 0, n_bad = 0;
   bit finished = 1'b0;
   logic [15:0] m_cnt;

   always #2.5 clk = ~clk;

   cct_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cap_pin(cap_pin), .cmp_pin(cmp_pin), .irq(irq)
   );

   // independent counter model from R2
   always @(posedge clk or negedge rst_n)
      if (!rst_n) m_cnt <= '0;
      else if (tick) m_cnt <= m_cnt + 16'd1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic op_rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); #1 bus_rd = 1'b0;
   endtask

   task automatic op_wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1 bus_wr = 1'b0;
   endtask

   task automatic rd16(input logic [3:0] a, output logic [15:0] v);
      logic [7:0] h, l;
      op_rd(a, h);
      op_rd(a + 4'd1, l);
      v = {h, l};
   endtask

   task automatic wr16(input logic [3:0] a, input logic [15:0] v);
      op_wr(a, v[15:8]);
      op_wr(a + 4'd1, v[7:0]);
   endtask

   task automatic peek(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk); bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_cnt(input logic [15:0] v);
      do begin @(negedge clk); #1; end while (m_cnt !== v);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [15:0] ahead(input logic [15:0] base, input int unsigned n);
      return base + 16'(n);
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0]  d, hi, lo;
      logic [15:0] v, exp, t, tv, cap0_exp, cap1_exp;
      void'($urandom(32'd2024));

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      op_rd(A_CNT_HI, d); chk("R1 cnt hi", d, 0);
      op_rd(A_CNT_LO, d); chk("R1 cnt lo", d, 0);
      peek(A_FLAG, d);    chk("R1 flags", d, 0);
      peek(A_IEN, d);     chk("R1 ien", d, 0);
      chk("R1 pins", cmp_pin, 0);
      chk("R1 irq", irq, 0);
      // R1/R8 compare channels disarmed: counter sweeps past stored value 0
      @(negedge clk) tick = 1'b1;
      idle(12);
      @(negedge clk) tick = 1'b0;
      idle(1);
      peek(A_FLAG, d); chk("R8 disarmed after reset flags", d[3:2], 0);
      chk("R8 disarmed after reset pins", cmp_pin, 0);

      // R2 coherent counter reads, random tick pauses
      for (int i = 0; i < 24; i++) begin
         repeat ($urandom_range(0, 5)) begin @(negedge clk); tick = 1'($urandom_range(0, 1)); end
         @(negedge clk); bus_rd = 1'b1; bus_addr = A_CNT_HI; tick = 1'($urandom_range(0, 1));
         #1 exp = m_cnt; hi = bus_rdata;
         @(posedge clk); #1 bus_rd = 1'b0;
         repeat ($urandom_range(1, 6)) begin @(negedge clk); tick = 1'($urandom_range(0, 1)); end
         op_rd(A_CNT_LO, lo);
         chk("R2 coherent counter", {hi, lo}, exp);
      end

      // R11 wrap flag
      @(negedge clk) tick = 1'b1;
      wait_cnt(16'hFFFF);
      bus_addr = A_FLAG; #0.5;
      chk("R11 wrap flag before", bus_rdata[4], 0);
      op_rd(A_FLAG, d); chk("R11 wrap flag set", d[4], 1);
      op_wr(A_FLAG, 8'h1F);
      peek(A_FLAG, d); chk("R9 w1c wrap", d, 0);

      // R12 writes to counter and capture offsets ignored
      @(negedge clk) tick = 1'b0;
      op_wr(A_CNT_HI, 8'hAA);
      op_wr(A_CNT_LO, 8'h55);
      op_wr(A_CAP0 + 4'd1, 8'h5A);
      exp = m_cnt;
      rd16(A_CNT_HI, v); chk("R12 counter unchanged", v, exp);
      rd16(A_CAP0, v);   chk("R12 capture unchanged", v, 0);
      @(negedge clk) tick = 1'b1;

      // R3 rising capture on channel 0, falling on channel 1
      op_wr(A_EDGE, 8'h01);
      @(negedge clk); cap_pin[0] = 1'b1; #1 cap0_exp = m_cnt;
      rd16(A_CAP0, v); chk("R3 rising capture value", v, cap0_exp);
      peek(A_FLAG, d); chk("R3 capture flag", d[0], 1);

      // R4 inactive edges ignored
      op_wr(A_FLAG, 8'h1F);
      @(negedge clk) cap_pin[0] = 1'b0;
      idle(2);
      peek(A_FLAG, d); chk("R4 falling ignored flag", d[0], 0);
      rd16(A_CAP0, v); chk("R4 falling ignored value", v, cap0_exp);
      @(negedge clk) cap_pin[1] = 1'b1;
      idle(2);
      peek(A_FLAG, d); chk("R4 rising ignored on ch1", d[1], 0);
      @(negedge clk); cap_pin[1] = 1'b0; #1 cap1_exp = m_cnt;
      rd16(A_CAP1, v); chk("R3 falling capture value", v, cap1_exp);
      peek(A_FLAG, d); chk("R3 falling capture flag", d[1], 1);

      // R5 high-byte read locks the capture
      op_wr(A_FLAG, 8'h1F);
      op_rd(A_CAP0, d); chk("R5 hi byte", d, cap0_exp[15:8]);
      @(negedge clk) cap_pin[0] = 1'b1;
      idle(3);
      peek(A_FLAG, d); chk("R5 blocked edge no flag", d[0], 0);
      op_rd(A_CAP0 + 4'd1, d); chk("R5 blocked edge no value", d, cap0_exp[7:0]);
      @(negedge clk) cap_pin[0] = 1'b0;
      idle(2);
      // same-cycle edge and high-byte read
      @(negedge clk); bus_rd = 1'b1; bus_addr = A_CAP0; cap_pin[0] = 1'b1;
      @(posedge clk); #1 bus_rd = 1'b0;
      idle(2);
      peek(A_FLAG, d); chk("R5 same-cycle edge no flag", d[0], 0);
      op_rd(A_CAP0 + 4'd1, d); chk("R5 same-cycle edge no value", d, cap0_exp[7:0]);
      @(negedge clk) cap_pin[0] = 1'b0;
      idle(2);
      @(negedge clk); cap_pin[0] = 1'b1; #1 cap0_exp = m_cnt;
      rd16(A_CAP0, v); chk("R5 capture after release", v, cap0_exp);

      // R6 toggle on match, channel 0
      op_wr(A_FLAG, 8'h1F);
      @(negedge clk); #1 t = ahead(m_cnt, 30 + $urandom_range(0, 40));
      wr16(A_CMP0, t);
      wait_cnt(t);
      chk("R6 pin before match", cmp_pin[0], 0);
      @(negedge clk); #1;
      chk("R6 pin toggled", cmp_pin[0], 1);
      peek(A_FLAG, d); chk("R6 compare flag", d[2], 1);

      // R7 level action on channel 1 (act bit1, level bit3)
      op_wr(A_ACT, 8'b0000_1010);
      @(negedge clk); #1 t = ahead(m_cnt, 25 + $urandom_range(0, 30));
      wr16(A_CMP1, t);
      wait_cnt(t);
      @(negedge clk); #1;
      chk("R7 level high", cmp_pin[1], 1);
      op_wr(A_FLAG, 8'h1F);
      @(negedge clk); #1 t = ahead(m_cnt, 25);
      wr16(A_CMP1, t);
      wait_cnt(t);
      @(negedge clk); #1;
      chk("R7 level held, no toggle", cmp_pin[1], 1);
      peek(A_FLAG, d); chk("R7 match flag", d[3], 1);
      chk("R7 other pin unchanged", cmp_pin[0], 1);

      // R8 high-byte write disarms channel 0
      op_wr(A_FLAG, 8'h1F);
      @(negedge clk); #1 tv = {m_cnt[15:8] + 8'd2, t[7:0]};
      op_wr(A_CMP0, tv[15:8]);
      rd16(A_CMP0, v); chk("R8 stored partial value", v, {tv[15:8], cap0_exp[7:0] ^ cap0_exp[7:0] ^ v[7:0]});
      wait_cnt(tv);
      @(negedge clk); #1;
      chk("R8 disarmed pin held", cmp_pin[0], 1);
      peek(A_FLAG, d); chk("R8 disarmed no flag", d[2], 0);
      @(negedge clk); #1 t = ahead(m_cnt, 30);
      wr16(A_CMP0, t);
      wait_cnt(t);
      @(negedge clk); #1;
      chk("R8 rearmed toggles", cmp_pin[0], 0);

      // R9 enables and irq
      op_wr(A_FLAG, 8'h1F);
      op_wr(A_IEN, 8'h00);
      @(negedge clk) cap_pin[0] = 1'b0;
      idle(2);
      @(negedge clk) cap_pin[0] = 1'b1;
      idle(2);
      peek(A_FLAG, d); chk("R9 flag without enable", d[0], 1);
      chk("R9 irq masked", irq, 0);
      op_wr(A_IEN, 8'h01);
      @(negedge clk); #1 chk("R9 irq enabled", irq, 1);
      op_wr(A_FLAG, 8'h01);
      @(negedge clk); #1 chk("R9 irq after clear", irq, 0);

      // R10 clear collides with a new capture
      @(negedge clk) cap_pin[0] = 1'b0;
      idle(2);
      @(negedge clk); bus_wr = 1'b1; bus_addr = A_FLAG; bus_wdata = 8'h01; cap_pin[0] = 1'b1;
      @(posedge clk); #1 bus_wr = 1'b0;
      peek(A_FLAG, d); chk("R10 set wins over clear", d[0], 1);
      chk("R10 irq follows", irq, 1);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule